// File: doc/BRIEF.md
# Tail-Biting Convolutional Decoder with Wrap-Around Passes

This block recovers one tail-biting codeword of a 64-state, rate-1/3 convolutional code with constraint length 7. The encoder register of such a code starts in the state given by the last six information bits. The decoder therefore does not know the start or end state. It solves this by running the Viterbi recursion over the circular trellis more than once. The metrics left at the end of one pass become the starting metrics of the next pass.

Software-free host logic first writes three signed soft values per trellis stage into an internal symbol buffer. It then presents a block length and pulses `start`. The decoder processes one trellis stage per clock with 64 parallel add-compare-select cells. After each pass it picks the survivor with the largest metric. If that survivor begins and ends in the same state, the decoder commits to it at once. Otherwise it either runs another pass or, when the pass cap is reached, falls back to the best survivor that is tail-biting. When no survivor is tail-biting, it uses the best survivor overall. Traceback fills a bit buffer in reverse, and the bits are then streamed out in forward order with a valid strobe. A done pulse follows the last bit, and a flag reports whether the emitted path was tail-biting.

Top module: `tbcc_wrap_decoder`

## Requirements
- R1: While and after reset, `bit_valid`, `done` and `tb_found` are 0.
- R2: Code bits for the transition with register r are parities of r AND 1011011b, 1111001b and 1110101b. Bit 6 of r is the current input and bit 0 is the input six stages earlier, with indices wrapping around the block. Write address t of the symbol buffer holds {y2,y1,y0}, each a 4-bit two's-complement soft value in which positive means code bit 1. For a clean, sign-only codeword of any length from 12 to 48, the decoder emits the original information bits and `tb_found` is 1.
- R3: A codeword with up to two sign-flipped soft values, well separated, still decodes to the original information bits.
- R4: Exactly `blk_len` strobes of `bit_valid` occur on consecutive cycles. The k-th strobe carries information bit k, so the first strobe carries the first bit encoded.
- R5: `done` is a single-cycle pulse. It comes one cycle after the last valid bit and is never high together with `bit_valid`.
- R6: When all soft inputs are zero, every candidate ties. Ties resolve to the predecessor whose dropped bit is 0 and to the lowest state index, so the output is all zeros with `tb_found` at 1.
- R7: When the first pass already yields a tail-biting best path, the first valid bit appears 2N+2 clock edges after the edge that samples `start`, and `done` appears 3N+2 edges after it.
- R8: For any input, at most 2 passes run, so `done` arrives no later than 3N+2+(N+1) edges after the sampling edge.
- R9: A `start` with `blk_len` equal to 0 or above 48 is ignored. No bit and no done appear.
- R10: A `start` pulse while a block is being decoded is ignored. The running block completes unchanged with exactly N bits.
- R11: `tb_found` is cleared when a start is accepted. It remains stable after `done` until the next accepted start.
- R12: Path metrics stay within range at full length with extreme soft values. A 48-stage all-zero codeword sent at soft value -8 decodes to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_we | input | 1 | Symbol buffer write enable |
| sym_addr | input | 6 | Stage index written |
| sym_data | input | 12 | Soft triple {y2,y1,y0}, 4 bits each |
| blk_len | input | 6 | Number of information bits, 1 to 48 |
| start | input | 1 | Begin decoding, sampled while idle |
| bit_out | output | 1 | Decoded bit, valid with bit_valid |
| bit_valid | output | 1 | Decoded bit strobe |
| done | output | 1 | One-cycle end-of-block pulse |
| tb_found | output | 1 | Emitted path starts and ends in the same state |

## Verification
The bench targets several ways this decoder can fail.

- A reversed traceback buffer would stream the bits backwards. A non-circular encoder model would break the first six bits of every block.
- Sign-flipped symbols test whether the correlation metrics really select the maximum-likelihood path.
- An all-zero input makes every candidate tie. A decoder without a fixed tie rule, or with a wrong initial start-state record, would emit garbage or clear the tail-biting flag.
- The bench counts cycles from start to the first bit and to done. A decoder that wasted a second pass on a clean block, or ran past the pass cap, shows up as a latency error.
- A full-length block at the most negative soft value stresses the metric renormalisation. Without it, a fixed-width metric would wrap and the decoder would pick wrong survivors.
- Invalid lengths and stray start pulses check that a control glitch cannot restart or hang the decoder.

// File: rtl/tbcc_pkg.sv
`timescale 1ns/1ps
package tbcc_pkg;
    localparam int CONSTR = 7;
    localparam int MEMB   = CONSTR - 1;
    localparam int NSTATE = 1 << MEMB;
    localparam int NOUT   = 3;
    localparam int NPAT   = 1 << NOUT;

    // generator taps, bit 6 = current input, bit 0 = oldest input
    localparam logic [CONSTR-1:0] TAP0 = 7'b1011011;
    localparam logic [CONSTR-1:0] TAP1 = 7'b1111001;
    localparam logic [CONSTR-1:0] TAP2 = 7'b1110101;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ACS   = 3'd1,
        PH_SEL   = 3'd2,
        PH_TRACE = 3'd3,
        PH_EMIT  = 3'd4,
        PH_FIN   = 3'd5
    } phase_e;

    function automatic logic [NOUT-1:0] code_of(input logic [CONSTR-1:0] r);
        code_of = {^(r & TAP2), ^(r & TAP1), ^(r & TAP0)};
    endfunction
endpackage

// File: rtl/tbcc_branch.sv
`timescale 1ns/1ps
module tbcc_branch
    import tbcc_pkg::*;
#(
    parameter int SW = 4,
    localparam int BW = SW + 2
)(
    input  logic [NOUT*SW-1:0]         sym,
    output logic [NPAT-1:0][BW-1:0]    bm
);
    // correlation of each soft value with the +/-1 image of a code pattern
    for (genvar c = 0; c < NPAT; c++) begin : g_pat
        logic [BW-1:0] acc;
        always_comb begin
            acc = '0;
            for (int k = 0; k < NOUT; k++) begin
                logic [SW-1:0] y;
                logic [BW-1:0] yx;
                y  = sym[k*SW +: SW];
                yx = {{(BW-SW){y[SW-1]}}, y};
                if (((c >> k) & 1) == 1) acc = acc + yx;
                else                     acc = acc - yx;
            end
        end
        assign bm[c] = acc;
    end
endmodule

// File: rtl/tbcc_acs_bank.sv
`timescale 1ns/1ps
module tbcc_acs_bank
    import tbcc_pkg::*;
#(
    parameter int PW = 12,
    parameter int BW = 6
)(
    input  logic [NSTATE-1:0][PW-1:0]   pm_in,
    input  logic [NSTATE-1:0][MEMB-1:0] st_in,
    input  logic [NPAT-1:0][BW-1:0]     bm,
    input  logic                        first,
    output logic [NSTATE-1:0][PW-1:0]   pm_out,
    output logic [NSTATE-1:0][MEMB-1:0] st_out,
    output logic [NSTATE-1:0]           dec
);
    logic [PW-1:0] mx;

    // largest metric of the previous stage, subtracted for renormalisation
    always_comb begin
        mx = pm_in[0];
        for (int i = 1; i < NSTATE; i++) begin
            if ($signed(pm_in[i]) > $signed(mx)) mx = pm_in[i];
        end
    end

    for (genvar ns = 0; ns < NSTATE; ns++) begin : g_cell
        localparam logic [CONSTR-1:0] R0 = CONSTR'(2 * ns);
        localparam logic [CONSTR-1:0] R1 = CONSTR'(2 * ns + 1);
        localparam logic [MEMB-1:0]   P0 = R0[MEMB-1:0];
        localparam logic [MEMB-1:0]   P1 = R1[MEMB-1:0];
        localparam logic [NOUT-1:0]   C0 = code_of(R0);
        localparam logic [NOUT-1:0]   C1 = code_of(R1);

        logic [PW-1:0] b0, b1, m0, m1;
        logic          take1;

        always_comb begin
            b0    = {{(PW-BW){bm[C0][BW-1]}}, bm[C0]};
            b1    = {{(PW-BW){bm[C1][BW-1]}}, bm[C1]};
            m0    = pm_in[P0] - mx + b0;
            m1    = pm_in[P1] - mx + b1;
            take1 = $signed(m1) > $signed(m0);
        end

        assign pm_out[ns] = take1 ? m1 : m0;
        assign dec[ns]    = take1;
        assign st_out[ns] = first ? (take1 ? P1 : P0)
                                  : (take1 ? st_in[P1] : st_in[P0]);
    end
endmodule

// File: rtl/tbcc_best_pick.sv
`timescale 1ns/1ps
module tbcc_best_pick
    import tbcc_pkg::*;
#(
    parameter int PW = 12
)(
    input  logic [NSTATE-1:0][PW-1:0]   pm,
    input  logic [NSTATE-1:0][MEMB-1:0] st,
    output logic [MEMB-1:0]             best_all,
    output logic [MEMB-1:0]             best_tb,
    output logic                        tb_any
);
    logic [PW-1:0] top_all, top_tb;

    // strict comparison keeps the lowest index on a tie
    always_comb begin
        best_all = '0;
        top_all  = pm[0];
        best_tb  = '0;
        top_tb   = '0;
        tb_any   = 1'b0;
        for (int s = 1; s < NSTATE; s++) begin
            if ($signed(pm[s]) > $signed(top_all)) begin
                top_all  = pm[s];
                best_all = MEMB'(s);
            end
        end
        for (int s = 0; s < NSTATE; s++) begin
            if (st[s] == MEMB'(s)) begin
                if (!tb_any || $signed(pm[s]) > $signed(top_tb)) begin
                    top_tb  = pm[s];
                    best_tb = MEMB'(s);
                end
                tb_any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tbcc_wrap_decoder.sv
`timescale 1ns/1ps
module tbcc_wrap_decoder
    import tbcc_pkg::*;
#(
    parameter int SW       = 4,
    parameter int PW       = 12,
    parameter int MAX_LEN  = 48,
    parameter int MAX_ITER = 2,
    localparam int LW   = $clog2(MAX_LEN),
    localparam int LENW = $clog2(MAX_LEN + 1),
    localparam int IW   = $clog2(MAX_ITER + 1),
    localparam int BW   = SW + 2
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sym_we,
    input  logic [LW-1:0]        sym_addr,
    input  logic [NOUT*SW-1:0]   sym_data,
    input  logic [LENW-1:0]      blk_len,
    input  logic                 start,
    output logic                 bit_out,
    output logic                 bit_valid,
    output logic                 done,
    output logic                 tb_found
);
    localparam int BM_TOP = NOUT * (1 << (SW - 1));
    localparam int PM_LIM = 1 << (PW - 2);

    typedef struct packed {
        phase_e                      ph;
        logic [LENW-1:0]             len;
        logic [LW-1:0]               idx;
        logic [IW-1:0]               pass;
        logic [NSTATE-1:0][PW-1:0]   pm;
        logic [NSTATE-1:0][MEMB-1:0] st;
        logic [MEMB-1:0]             end_st;
        logic [MEMB-1:0]             trc;
        logic                        tbok;
        logic [MAX_LEN-1:0]          bits;
        logic                        bit_o;
        logic                        vld;
        logic                        dn;
    } regs_t;

    regs_t q, n;

    logic [NOUT*SW-1:0] sym_mem [MAX_LEN];
    logic [NSTATE-1:0]  dec_mem [MAX_LEN];

    logic [NOUT*SW-1:0]          sym_rd;
    logic [NPAT-1:0][BW-1:0]     bm;
    logic [NSTATE-1:0][PW-1:0]   acs_pm;
    logic [NSTATE-1:0][MEMB-1:0] acs_st;
    logic [NSTATE-1:0]           acs_dec;
    logic [MEMB-1:0]             best_all, best_tb;
    logic                        tb_any;
    logic                        last_idx;
    logic                        dec_bit;

    assign sym_rd   = sym_mem[q.idx];
    assign dec_bit  = dec_mem[q.idx][q.trc];
    assign last_idx = (LENW'(q.idx) == q.len - LENW'(1));

    tbcc_branch #(.SW(SW)) u_branch (
        .sym (sym_rd),
        .bm  (bm)
    );

    tbcc_acs_bank #(.PW(PW), .BW(BW)) u_acs (
        .pm_in  (q.pm),
        .st_in  (q.st),
        .bm     (bm),
        .first  (q.idx == '0),
        .pm_out (acs_pm),
        .st_out (acs_st),
        .dec    (acs_dec)
    );

    tbcc_best_pick #(.PW(PW)) u_pick (
        .pm       (q.pm),
        .st       (q.st),
        .best_all (best_all),
        .best_tb  (best_tb),
        .tb_any   (tb_any)
    );

    always_comb begin
        logic            go_trace;
        logic [MEMB-1:0] chosen;
        n        = q;
        n.vld    = 1'b0;
        n.dn     = 1'b0;
        n.bit_o  = 1'b0;
        go_trace = 1'b0;
        chosen   = best_all;
        case (q.ph)
            PH_IDLE: begin
                if (start && blk_len != '0 && blk_len <= LENW'(MAX_LEN)) begin
                    n.ph   = PH_ACS;
                    n.len  = blk_len;
                    n.idx  = '0;
                    n.pass = IW'(1);
                    n.pm   = '0;
                    n.tbok = 1'b0;
                end
            end
            PH_ACS: begin
                n.pm = acs_pm;
                n.st = acs_st;
                if (last_idx) n.ph = PH_SEL;
                else          n.idx = q.idx + 1'b1;
            end
            PH_SEL: begin
                if (q.st[best_all] == best_all) begin
                    go_trace = 1'b1;
                    n.tbok   = 1'b1;
                end else if (q.pass < IW'(MAX_ITER)) begin
                    n.pass = q.pass + 1'b1;
                    n.idx  = '0;
                    n.ph   = PH_ACS;
                end else begin
                    go_trace = 1'b1;
                    chosen   = tb_any ? best_tb : best_all;
                    n.tbok   = tb_any;
                end
                if (go_trace) begin
                    n.end_st = chosen;
                    n.trc    = chosen;
                    n.idx    = LW'(q.len - LENW'(1));
                    n.ph     = PH_TRACE;
                end
            end
            PH_TRACE: begin
                n.bits[q.idx] = q.trc[MEMB-1];
                n.trc         = {q.trc[MEMB-2:0], dec_bit};
                if (q.idx == '0) n.ph  = PH_EMIT;
                else             n.idx = q.idx - 1'b1;
            end
            PH_EMIT: begin
                n.vld   = 1'b1;
                n.bit_o = q.bits[q.idx];
                if (last_idx) n.ph  = PH_FIN;
                else          n.idx = q.idx + 1'b1;
            end
            PH_FIN: begin
                n.dn = 1'b1;
                n.ph = PH_IDLE;
            end
            default: n.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (sym_we) sym_mem[sym_addr] <= sym_data;
        if (q.ph == PH_ACS) dec_mem[q.idx] <= acs_dec;
    end

    assign bit_out   = q.bit_o;
    assign bit_valid = q.vld;
    assign done      = q.dn;
    assign tb_found  = q.tbok;

    logic pm_in_range;
    always_comb begin
        pm_in_range = 1'b1;
        for (int s = 0; s < NSTATE; s++) begin
            if ($signed(q.pm[s]) > BM_TOP || $signed(q.pm[s]) < -PM_LIM)
                pm_in_range = 1'b0;
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && bit_valid));

    // R8
    pass_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pass <= IW'(MAX_ITER));

    // R2: traceback through decisions must land on the recorded start state
    trace_closure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_TRACE && q.idx == '0 && q.tbok) |=> (q.trc == q.end_st));

    // R12
    metric_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_in_range);
endmodule

// File: tb/tbcc_wrap_decoder_test.sv
`timescale 1ns/1ps
module tbcc_wrap_decoder_test;
    localparam int SW = 4;
    localparam int MAXL = 48;
    localparam int ITERS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_we = 1'b0;
    logic [5:0]  sym_addr = '0;
    logic [11:0] sym_data = '0;
    logic [5:0]  blk_len = '0;
    logic        start = 1'b0;
    logic        bit_out, bit_valid, done, tb_found;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tbcc_wrap_decoder uut (
        .clk(clk), .rst_n(rst_n), .sym_we(sym_we), .sym_addr(sym_addr),
        .sym_data(sym_data), .blk_len(blk_len), .start(start),
        .bit_out(bit_out), .bit_valid(bit_valid), .done(done), .tb_found(tb_found)
    );

    // {len[7:0], info bits[47:0], flip position A[7:0], flip position B[7:0]}; 255 = none
    localparam logic [71:0] VEC [6] = '{
        {8'd24, 48'h0000_00A5_C3F1, 8'd255, 8'd255},
        {8'd48, 48'hDEAD_BEEF_1234, 8'd255, 8'd255},
        {8'd32, 48'h0000_9C3B_71E4, 8'd5,   8'd60},
        {8'd48, 48'h5A5A_0F0F_C3C3, 8'd20,  8'd100},
        {8'd12, 48'h0000_0000_0B6D, 8'd255, 8'd255},
        {8'd40, 48'h00F0_0F1E_2D3C, 8'd90,  8'd255}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] encode_at(input logic [47:0] msg, input int len, input int t);
        logic [6:0] r;
        for (int j = 0; j < 7; j++) r[6-j] = msg[(t - j + 7*len) % len];
        encode_at = {^(r & 7'b1110101), ^(r & 7'b1111001), ^(r & 7'b1011011)};
    endfunction

    task automatic load_code(input int len, input logic [47:0] msg,
                             input int fa, input int fb, input int amp);
        for (int t = 0; t < len; t++) begin
            logic [2:0]  c;
            logic [11:0] d;
            c = encode_at(msg, len, t);
            for (int k = 0; k < 3; k++) begin
                int v;
                v = c[k] ? amp : -amp;
                if (3*t + k == fa || 3*t + k == fb) v = -v;
                d[k*4 +: 4] = 4'(v);
            end
            @(negedge clk);
            sym_we = 1'b1; sym_addr = 6'(t); sym_data = d;
        end
        @(negedge clk);
        sym_we = 1'b0;
    endtask

    task automatic run_dec(input int len, input int inject,
                           output logic [47:0] got, output int nv,
                           output int fl, output int dl, output logic tb_clr,
                           output logic cons, output logic pulse_ok);
        int s, last;
        @(negedge clk);
        blk_len = 6'(len); start = 1'b1; s = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        tb_clr = !tb_found;
        got = '0; nv = 0; fl = -1; dl = -1; last = -1; cons = 1'b1; pulse_ok = 1'b1;
        while (dl < 0 && cyc < s + 600) begin
            if (bit_valid) begin
                if (fl < 0) fl = cyc - s;
                else if (cyc != last + 1) cons = 1'b0;
                if (nv < 48) got[nv] = bit_out;
                nv++;
                last = cyc;
            end
            if (done) begin
                dl = cyc - s;
                if (last != cyc - 1) pulse_ok = 1'b0;
            end
            start = (inject > 0 && cyc == s + inject);
            @(negedge clk);
        end
        start = 1'b0;
        if (done) pulse_ok = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [47:0] got, msk;
        int nv, fl, dl, len;
        logic tbc, cons, pok;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!bit_valid && !done && !tb_found, "R1", "outputs in reset",
            {bit_valid, done, tb_found}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bit_valid && !done && !tb_found, "R1", "outputs after reset",
            {bit_valid, done, tb_found}, 0);

        for (int v = 0; v < 6; v++) begin
            int fa, fb;
            len = int'(VEC[v][71:64]);
            fa  = int'(VEC[v][15:8]);
            fb  = int'(VEC[v][7:0]);
            msk = (48'd1 << len) - 48'd1;
            load_code(len, VEC[v][63:16], fa, fb, 7);
            run_dec(len, 0, got, nv, fl, dl, tbc, cons, pok);
            // R2 / R3: decoded bits match the information bits
            chk(got == (VEC[v][63:16] & msk), (fa == 255) ? "R2" : "R3",
                "decoded bits", got, VEC[v][63:16] & msk);
            chk(tb_found, "R2", "tail-biting flag", tb_found, 1);
            chk(nv == len && cons, "R4", "valid count and contiguity", nv, len);
            chk(pok, "R5", "done after last bit as one pulse", pok, 1);
            chk(fl == 2*len + 2 && dl == 3*len + 2, "R7", "single-pass latency",
                dl, 3*len + 2);
            chk(tbc, "R11", "flag cleared on start", tbc, 1);
        end

        // R11: flag holds after done
        repeat (20) @(negedge clk);
        chk(tb_found, "R11", "flag held after done", tb_found, 1);

        // R6: all-zero soft values
        load_code(30, 48'h0000_3FFF_FFFF, 255, 255, 0);
        run_dec(30, 0, got, nv, fl, dl, tbc, cons, pok);
        chk(got == 48'd0 && nv == 30, "R6", "tie resolution bits", got, 0);
        chk(tb_found, "R6", "tie resolution flag", tb_found, 1);

        // R12: full length at the most negative soft value
        load_code(48, 48'd0, 255, 255, 8);
        run_dec(48, 0, got, nv, fl, dl, tbc, cons, pok);
        chk(got == 48'd0 && nv == 48, "R12", "extreme soft decode", got, 0);

        // R10: start pulse while busy
        load_code(36, 48'h0000_0F1C_2B39, 255, 255, 7);
        run_dec(36, 5, got, nv, fl, dl, tbc, cons, pok);
        chk(got == 48'h0000_0F1C_2B39 && nv == 36, "R10", "busy start ignored",
            got, 48'h0000_0F1C_2B39);
        repeat (150) @(negedge clk);
        chk(!bit_valid && !done, "R10", "no second run", {bit_valid, done}, 0);

        // R8: scrambled input, pass cap bounds the latency
        for (int t = 0; t < 40; t++) begin
            logic [11:0] d;
            for (int k = 0; k < 3; k++) d[k*4 +: 4] = 4'(((t*5 + k*11 + t*t) % 15) - 7);
            @(negedge clk);
            sym_we = 1'b1; sym_addr = 6'(t); sym_data = d;
        end
        @(negedge clk);
        sym_we = 1'b0;
        run_dec(40, 0, got, nv, fl, dl, tbc, cons, pok);
        chk(dl > 0 && dl <= 3*40 + 2 + (ITERS - 1)*(40 + 1), "R8", "done bound",
            dl, 3*40 + 2 + (ITERS - 1)*41);
        chk(nv == 40 && cons, "R4", "bit count on noisy block", nv, 40);

        // R9: invalid lengths
        for (int b = 0; b < 2; b++) begin
            int seen;
            seen = 0;
            @(negedge clk);
            blk_len = (b == 0) ? 6'd0 : 6'd49; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int w = 0; w < 200; w++) begin
                if (bit_valid || done) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R9", "invalid length ignored", seen, 0);
        end

        // R9: still operational afterwards
        load_code(20, 48'h0000_000A_B3C5, 255, 255, 7);
        run_dec(20, 0, got, nv, fl, dl, tbc, cons, pok);
        chk(got == 48'h0000_000A_B3C5 && nv == 20, "R9", "decode after ignored starts",
            got, 48'h0000_000A_B3C5);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule